// File: doc/BRIEF.md
# Multiplexed BCD Digit Scanner with Strobe

This block drives a multiplexed five-digit decimal readout from the result of an integrating converter. When the measurement sequencer signals that a result is final, the block captures the five BCD digits and the overrange flag. It then scans them out one digit position at a time on a shared 4-bit BCD bus, together with a one-hot digit-select. The most significant position comes first, and the scan keeps running until the next result arrives.

For each captured result, the block emits exactly five active-low strobe pulses, one in the middle of each digit slot. An external latch, serial transmitter or processor can use them to take the value without racing the digit changes. After the fifth strobe, if the captured result was overrange, the block switches off every digit drive. The drives stay off until the sequencer reports the start of reference integration. The scan then restarts at the most significant digit, which makes the readout blink.

Top module: `bcd_digit_scanner`

## Requirements
- R1: While reset is held, `dig_sel` is 5'b10000 (most significant position), `bcd` is 0 and `strobe_n` is 1.
- R2: Bit 4 of `dig_sel` selects the most significant digit and bit 0 the least. The scan steps 4,3,2,1,0 and then wraps to 4 indefinitely. Every slot lasts 200 clocks except the one in R3.
- R3: In the clock after `cycle_end` is sampled high, the scan restarts at position 4 and that slot lasts 201 clocks. The block's own `digits_in` and `ovr_in` are captured on the same edge.
- R4: `bcd` equals the captured digit of the selected position, where position i is `digits_in[4i+3:4i]`. It changes in the same cycle as `dig_sel`. Changes of `digits_in` between `cycle_end` pulses have no effect.
- R5: `strobe_n` is low for exactly one clock. The first low clock comes 101 clocks after the `cycle_end` edge. Each later low clock comes 100 clocks into its slot.
- R6: Exactly five strobes follow each `cycle_end`. No further strobe appears until the next `cycle_end`, and a `cycle_end` during a burst starts a fresh burst of five.
- R7: If the captured overrange flag is 1, `dig_sel` and `bcd` are both 0 from the clock after the fifth strobe onward.
- R8: A `refint_start` pulse while blanked ends the blanking and restarts the scan at position 4 with a 200-clock slot. A `refint_start` while not blanked has no effect.
- R9: When `cycle_end` and `refint_start` are high in the same cycle, `cycle_end` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cycle_end | input | 1 | One-clock pulse: measurement result is final |
| refint_start | input | 1 | One-clock pulse: reference integration begins |
| digits_in | input | 20 | Five BCD digits, position i at bits 4i+3:4i |
| ovr_in | input | 1 | Overrange flag of the final result |
| dig_sel | output | 5 | One-hot digit drive, bit 4 = most significant |
| bcd | output | 4 | BCD value of the selected digit |
| strobe_n | output | 1 | Active-low mid-slot strobe |

## Verification
The captured digit pattern is swept so that every position shows every value 0 to 9. Meanwhile `digits_in` carries a different pattern, so a design that reads the live inputs gives itself away. The scan is followed for more than a full 1000-clock period after each capture, and also from reset with no capture at all. This separates the 201-clock first slot from ordinary slots and a single burst of five strobes from a repeating one. The overrange runs end with a `refint_start`, and stray `refint_start` pulses arrive outside blanking. A simultaneous `cycle_end` and `refint_start` shows which of the two events takes priority over the other.

// File: rtl/scan_pkg.sv
package scan_pkg;

  // Last counter value of a slot (slot length minus one, plus the stretch).
  function automatic int slot_last_cnt(int slot_len, int extra, bit long_slot);
    return slot_len - 1 + (long_slot ? extra : 0);
  endfunction

  // Counter value at which the strobe sits inside a slot.
  function automatic int strobe_cnt(int slot_len, int extra, bit long_slot);
    return slot_len / 2 + (long_slot ? extra : 0);
  endfunction

endpackage

// File: rtl/scan_slot_timer.sv
module scan_slot_timer #(
  parameter int NUM_DIGITS  = 5,
  parameter int SLOT_LEN    = 200,
  parameter int FIRST_EXTRA = 1,
  parameter int IDX_W       = 3,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             resume,
  output logic [IDX_W-1:0] idx,
  output logic             at_mid,
  output logic             wrap
);
  import scan_pkg::*;

  localparam logic [IDX_W-1:0] MSD    = IDX_W'(NUM_DIGITS - 1);
  localparam logic [CNT_W-1:0] LAST_N = CNT_W'(slot_last_cnt(SLOT_LEN, FIRST_EXTRA, 1'b0));
  localparam logic [CNT_W-1:0] LAST_L = CNT_W'(slot_last_cnt(SLOT_LEN, FIRST_EXTRA, 1'b1));
  localparam logic [CNT_W-1:0] MID_N  = CNT_W'(strobe_cnt(SLOT_LEN, FIRST_EXTRA, 1'b0));
  localparam logic [CNT_W-1:0] MID_L  = CNT_W'(strobe_cnt(SLOT_LEN, FIRST_EXTRA, 1'b1));

  logic [CNT_W-1:0] cnt_q;
  logic             long_q;

  assign wrap   = (cnt_q == (long_q ? LAST_L : LAST_N));
  assign at_mid = (cnt_q == (long_q ? MID_L : MID_N));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      idx    <= MSD;
      long_q <= 1'b0;
    end else if (restart) begin
      cnt_q  <= '0;
      idx    <= MSD;
      long_q <= 1'b1;
    end else if (resume) begin
      cnt_q  <= '0;
      idx    <= MSD;
      long_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      long_q <= 1'b0;
      idx    <= (idx == '0) ? MSD : idx - IDX_W'(1);
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/scan_strobe_gen.sv
module scan_strobe_gen #(
  parameter int NUM_DIGITS   = 5,
  parameter int LEFT_W       = 3,
  parameter bit STROBE_GATED = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic at_mid,
  output logic fire,
  output logic last_fire,
  output logic strobe_n
);
  logic [LEFT_W-1:0] left_q;

  assign fire      = at_mid && (left_q != '0);
  assign last_fire = fire && (left_q == LEFT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)       left_q <= '0;
    else if (restart) left_q <= LEFT_W'(NUM_DIGITS);
    else if (fire)    left_q <= left_q - LEFT_W'(1);
  end

  generate
    if (STROBE_GATED) begin : g_half
      // low only during the low clock phase of the firing cycle
      assign strobe_n = ~(fire & ~clk);
    end else begin : g_full
      // one full cycle, standing for one cycle of a doubled clock
      assign strobe_n = ~fire;
    end
  endgenerate
endmodule

// File: rtl/scan_blank_ctl.sv
module scan_blank_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic ovr_in,
  input  logic refint_start,
  input  logic last_fire,
  output logic blank,
  output logic resume
);
  logic ovr_q;

  assign resume = refint_start && blank && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      blank <= 1'b0;
    end else if (restart) begin
      ovr_q <= ovr_in;
      blank <= 1'b0;
    end else if (resume) begin
      ovr_q <= 1'b0;
      blank <= 1'b0;
    end else if (last_fire && ovr_q) begin
      blank <= 1'b1;
    end
  end
endmodule

// File: rtl/bcd_digit_scanner.sv
module bcd_digit_scanner #(
  parameter int NUM_DIGITS   = 5,
  parameter int SLOT_LEN     = 200,
  parameter int FIRST_EXTRA  = 1,
  parameter bit STROBE_GATED = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cycle_end,
  input  logic                    refint_start,
  input  logic [NUM_DIGITS*4-1:0] digits_in,
  input  logic                    ovr_in,
  output logic [NUM_DIGITS-1:0]   dig_sel,
  output logic [3:0]              bcd,
  output logic                    strobe_n
);
  localparam int IDX_W  = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;
  localparam int CNT_W  = $clog2(SLOT_LEN + FIRST_EXTRA + 1);
  localparam int LEFT_W = $clog2(NUM_DIGITS + 1);

  logic [NUM_DIGITS*4-1:0] digits_q;
  logic [IDX_W-1:0]        idx;
  logic                    at_mid;
  logic                    slot_wrap;
  logic                    strobe_fire;
  logic                    last_fire;
  logic                    blank;
  logic                    resume;
  logic [3:0]              bcd_pick;

  always_ff @(posedge clk) begin
    if (!rst_n)         digits_q <= '0;
    else if (cycle_end) digits_q <= digits_in;
  end

  scan_slot_timer #(
    .NUM_DIGITS(NUM_DIGITS), .SLOT_LEN(SLOT_LEN), .FIRST_EXTRA(FIRST_EXTRA),
    .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(cycle_end), .resume(resume),
    .idx(idx), .at_mid(at_mid), .wrap(slot_wrap)
  );

  scan_strobe_gen #(
    .NUM_DIGITS(NUM_DIGITS), .LEFT_W(LEFT_W), .STROBE_GATED(STROBE_GATED)
  ) u_strobe (
    .clk(clk), .rst_n(rst_n), .restart(cycle_end), .at_mid(at_mid),
    .fire(strobe_fire), .last_fire(last_fire), .strobe_n(strobe_n)
  );

  scan_blank_ctl u_blank (
    .clk(clk), .rst_n(rst_n), .restart(cycle_end), .ovr_in(ovr_in),
    .refint_start(refint_start), .last_fire(last_fire),
    .blank(blank), .resume(resume)
  );

  generate
    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_sel
      assign dig_sel[g] = !blank && (idx == IDX_W'(g));
    end
  endgenerate

  always_comb begin
    bcd_pick = 4'd0;
    for (int i = 0; i < NUM_DIGITS; i++) begin
      if (idx == IDX_W'(i)) bcd_pick = digits_q[i*4 +: 4];
    end
  end

  assign bcd = blank ? 4'd0 : bcd_pick;
endmodule

// File: rtl/bcd_digit_scanner_chk.sv
module bcd_digit_scanner_chk #(
  parameter int NUM_DIGITS = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cycle_end,
  input logic                  refint_start,
  input logic [NUM_DIGITS-1:0] dig_sel,
  input logic [3:0]            bcd,
  input logic                  strobe_fire,
  input logic                  last_fire,
  input logic                  blank
);
  localparam logic [NUM_DIGITS-1:0] MSD_SEL = NUM_DIGITS'(1) << (NUM_DIGITS - 1);

  a_r2_onehot_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dig_sel));

  a_r3_restart_at_msd: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_end |=> (dig_sel == MSD_SEL));

  a_r4_bcd_follows_select: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cycle_end) && $stable(dig_sel) && dig_sel != '0) |-> $stable(bcd));

  a_r5_strobe_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_fire |=> !strobe_fire);

  a_r6_no_strobe_blanked: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> !strobe_fire);

  a_r7_blank_after_burst: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blank) |-> $past(last_fire));

  a_r8_resume_at_msd: assert property (@(posedge clk) disable iff (!rst_n)
    (refint_start && blank && !cycle_end) |=> (dig_sel == MSD_SEL));
endmodule

bind bcd_digit_scanner bcd_digit_scanner_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cycle_end(cycle_end), .refint_start(refint_start),
  .dig_sel(dig_sel), .bcd(bcd), .strobe_fire(strobe_fire),
  .last_fire(last_fire), .blank(blank)
);

// File: tb/tb_bcd_digit_scanner.sv
module tb_bcd_digit_scanner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cycle_end = 1'b0;
  logic        refint_start = 1'b0;
  logic [19:0] digits_in = '0;
  logic        ovr_in = 1'b0;
  logic [4:0]  dig_sel;
  logic [3:0]  bcd;
  logic        strobe_n;

  bcd_digit_scanner dut (
    .clk(clk), .rst_n(rst_n), .cycle_end(cycle_end), .refint_start(refint_start),
    .digits_in(digits_in), .ovr_in(ovr_in), .dig_sel(dig_sel), .bcd(bcd),
    .strobe_n(strobe_n)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  // model state: clocks since last restart, whether that slot is stretched
  int          t = 0;
  bit          fl = 1'b0;
  bit          meas = 1'b0;
  bit          ovr_m = 1'b0;
  bit          blank_m = 1'b0;
  logic [19:0] dm = '0;

  function automatic int exp_idx(int tt, bit first_long);
    int u;
    if (first_long) begin
      if (tt <= 200) return 4;
      u = tt - 201 + 200;
    end else begin
      u = tt;
    end
    return 4 - ((u / 200) % 5);
  endfunction

  function automatic bit exp_strobe(int tt);
    return (tt == 101) || (tt >= 301 && tt <= 901 && ((tt - 301) % 200) == 0);
  endfunction

  function automatic logic [19:0] pattern(int k);
    logic [19:0] p;
    for (int i = 0; i < 5; i++) p[i*4 +: 4] = 4'((k + i) % 10);
    return p;
  endfunction

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s t=%0d got=%0h exp=%0h", tag, t, got, exp);
    end
  endtask

  task automatic tick(bit ce, bit ri, logic [19:0] d, bit ov, string tag);
    int idx;
    cycle_end = ce; refint_start = ri; digits_in = d; ovr_in = ov;
    @(negedge clk);
    if (ce) begin
      t = 0; fl = 1'b1; meas = 1'b1; ovr_m = ov; dm = d; blank_m = 1'b0;
    end else if (ri && blank_m) begin
      t = 0; fl = 1'b0; meas = 1'b0; ovr_m = 1'b0; blank_m = 1'b0;
    end else begin
      t++;
      if (meas && ovr_m && t >= 902) blank_m = 1'b1;
    end
    idx = exp_idx(t, fl);
    check({tag, " sel"}, int'(dig_sel), blank_m ? 0 : (1 << idx));
    check({tag, " bcd"}, int'(bcd), blank_m ? 0 : int'(dm[idx*4 +: 4]));
    check({tag, " strobe"}, int'(strobe_n), (meas && exp_strobe(t)) ? 0 : 1);
    cycle_end = 1'b0; refint_start = 1'b0;
  endtask

  task automatic run(int n, logic [19:0] d, string tag);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0, d, 1'b0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 sel", int'(dig_sel), 5'b10000);
    check("R1 bcd", int'(bcd), 0);
    check("R1 strobe", int'(strobe_n), 1);
    rst_n = 1'b1;
    t = 0;
    // R2: free scan from reset, no strobes
    run(1200, 20'h12345, "R2/R4");

    // R3/R4/R5/R6: sweep every value through every position, live inputs differ
    for (int k = 0; k < 10; k++) begin
      tick(1'b1, 1'b0, pattern(k), 1'b0, "R3");
      run(1000, pattern(k + 3), "R2/R4/R5");
    end
    // R6: long quiet stretch, then a stray refint_start (R8: no effect)
    run(900, 20'h99999, "R6");
    tick(1'b0, 1'b1, 20'h99999, 1'b0, "R8");
    run(300, 20'h99999, "R8");

    // R6: restart in the middle of a burst
    tick(1'b1, 1'b0, 20'h13579, 1'b0, "R6");
    run(500, 20'h0, "R6");
    tick(1'b1, 1'b0, 20'h24680, 1'b0, "R6");
    run(1100, 20'h0, "R5/R6");

    // R7/R8: overrange blanking and resume
    tick(1'b1, 1'b0, 20'h20000, 1'b1, "R7");
    run(1500, 20'h0, "R7");
    tick(1'b0, 1'b1, 20'h0, 1'b0, "R8");
    run(1200, 20'h0, "R8");

    // R9: both pulses while blanked, cycle_end wins
    tick(1'b1, 1'b0, 20'h31415, 1'b1, "R7");
    run(1000, 20'h0, "R7");
    tick(1'b1, 1'b1, 20'h27182, 1'b0, "R9");
    run(1100, 20'h0, "R9");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(300_000 * 10);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog (R1..) got=running exp=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule